// File: doc/BRIEF.md
# X-Y Display Pair Router

The router takes the three state variables (u, v, w) of a chaotic generator at three rotation angles (0, -45 and -90 degrees), nine 14-bit samples in all. It forwards two of them to the two channels of a dual DAC, which feed the X and Y deflection of an oscilloscope. Switches pick a projection: u against v, u against w, or v against w. They also pick one angle, or two angles when automatic mode is on.

In manual mode the projection of the first selected angle is shown steadily. In automatic mode a slow refresh tick moves the display back and forth between the first and the second angle, so both rotations of the same projection appear overlaid. The tick comes from a divider on the system clock. The default divide ratio of 500,000 turns a 15 MHz clock into a 30 Hz alternation. The system clock is also forwarded unchanged as the DAC sample clock.

Top module: `xy_scope_router`

## Requirements
- R1: While reset is asserted both outputs read zero. Reset clears the alternation phase, so the first registered automatic-mode output after reset release comes from the first angle.
- R2: In manual mode (`auto_mode`=0) the pair comes from the angle on `ang_first`, coded 0 = 0 deg, 1 = -45 deg, 2 = -90 deg. `proj_sel` 0 gives (X,Y) = (u,v), 1 gives (u,w), and 2 gives (v,w).
- R3: In manual mode `ang_second` and the alternation phase have no effect on the outputs.
- R4: `proj_sel` = 3 routes (u,v).
- R5: An angle code of 3 on either angle input selects the 0 deg signals.
- R6: In automatic mode, the first TICK_DIV registered outputs after reset release come from `ang_first`. The next TICK_DIV outputs come from `ang_second`, and the two angles keep alternating in blocks of TICK_DIV clock cycles.
- R7: The outputs are registered. A change of the samples or switches before a rising edge appears on `sig_x`/`sig_y` at that edge, and not earlier.
- R8: `dac_clk` follows the system clock `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| u_deg0 | input | 14 | u at 0 deg |
| v_deg0 | input | 14 | v at 0 deg |
| w_deg0 | input | 14 | w at 0 deg |
| u_deg45 | input | 14 | u at -45 deg |
| v_deg45 | input | 14 | v at -45 deg |
| w_deg45 | input | 14 | w at -45 deg |
| u_deg90 | input | 14 | u at -90 deg |
| v_deg90 | input | 14 | v at -90 deg |
| w_deg90 | input | 14 | w at -90 deg |
| auto_mode | input | 1 | 1 = alternate between two angles |
| ang_first | input | 2 | Angle for manual mode and the first automatic phase |
| ang_second | input | 2 | Angle for the second automatic phase |
| proj_sel | input | 2 | Projection code |
| sig_x | output | 14 | DAC channel A sample (X) |
| sig_y | output | 14 | DAC channel B sample (Y) |
| dac_clk | output | 1 | DAC sample clock |

## Verification
Every sample input carries a value that encodes its angle, its component and a stamp that changes on each cycle. A wrong angle, a swapped component or a stale cycle therefore each produce a distinct mismatch. A manual sweep covers all sixteen angle/projection codes, including the invalid ones. Further manual runs move `ang_second` across several tick boundaries, which shows whether the phase leaks into manual mode. Automatic runs span several ticks with different angle pairs, which pins down the exact edge where the phase changes. A reset in the middle of the second phase shows that the alternation restarts on the first angle.

// File: rtl/xy_scope_router.sv
module xy_scope_router #(
  parameter int W        = 14,
  parameter int TICK_DIV = 500000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] u_deg0,
  input  logic [W-1:0] v_deg0,
  input  logic [W-1:0] w_deg0,
  input  logic [W-1:0] u_deg45,
  input  logic [W-1:0] v_deg45,
  input  logic [W-1:0] w_deg45,
  input  logic [W-1:0] u_deg90,
  input  logic [W-1:0] v_deg90,
  input  logic [W-1:0] w_deg90,
  input  logic         auto_mode,
  input  logic [1:0]   ang_first,
  input  logic [1:0]   ang_second,
  input  logic [1:0]   proj_sel,
  output logic [W-1:0] sig_x,
  output logic [W-1:0] sig_y,
  output logic         dac_clk
);

  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] tick_cnt;
  logic          alt_q;
  logic          tick;
  logic [1:0]    ang;
  logic [W-1:0]  su, sv, sw;
  logic [W-1:0]  nx, ny;

  assign dac_clk = clk;
  assign tick    = (tick_cnt == LAST);
  assign ang     = (auto_mode && alt_q) ? ang_second : ang_first;

  // refresh divider: one phase flip every TICK_DIV cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      alt_q    <= 1'b0;
    end else if (tick) begin
      tick_cnt <= '0;
      alt_q    <= ~alt_q;
    end else begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  always_comb begin
    case (ang)
      2'd1:    begin su = u_deg45; sv = v_deg45; sw = w_deg45; end
      2'd2:    begin su = u_deg90; sv = v_deg90; sw = w_deg90; end
      default: begin su = u_deg0;  sv = v_deg0;  sw = w_deg0;  end
    endcase
  end

  always_comb begin
    case (proj_sel)
      2'd1:    begin nx = su; ny = sw; end
      2'd2:    begin nx = sv; ny = sw; end
      default: begin nx = su; ny = sv; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_x <= '0;
      sig_y <= '0;
    end else begin
      sig_x <= nx;
      sig_y <= ny;
    end
  end

endmodule

// File: rtl/xy_scope_router_chk.sv
module xy_scope_router_chk #(
  parameter int W        = 14,
  parameter int TICK_DIV = 500000
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] u_deg0,
  input logic [W-1:0] v_deg0,
  input logic [W-1:0] u_deg45,
  input logic [W-1:0] v_deg45,
  input logic [W-1:0] v_deg90,
  input logic [W-1:0] w_deg90,
  input logic         auto_mode,
  input logic [1:0]   ang_first,
  input logic [1:0]   ang_second,
  input logic [1:0]   proj_sel,
  input logic [W-1:0] sig_x,
  input logic [W-1:0] sig_y,
  input logic [((TICK_DIV > 2) ? $clog2(TICK_DIV) : 1)-1:0] tick_cnt,
  input logic         alt_q
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (sig_x == '0 && sig_y == '0));

  p_manual_uv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && ang_first == 2'd0 && proj_sel == 2'd0)
    |=> (sig_x == $past(u_deg0) && sig_y == $past(v_deg0)));

  p_bad_proj_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && ang_first == 2'd1 && proj_sel == 2'd3)
    |=> (sig_x == $past(u_deg45) && sig_y == $past(v_deg45)));

  p_second_angle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && alt_q && ang_second == 2'd2 && proj_sel == 2'd2)
    |=> (sig_x == $past(v_deg90) && sig_y == $past(w_deg90)));

  p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_cnt != CW'(TICK_DIV - 1)) |=> $stable(alt_q));

  p_phase_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_cnt == CW'(TICK_DIV - 1)) |=> (alt_q != $past(alt_q)));
endmodule

bind xy_scope_router xy_scope_router_chk #(.W(W), .TICK_DIV(TICK_DIV)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .u_deg0(u_deg0), .v_deg0(v_deg0),
  .u_deg45(u_deg45), .v_deg45(v_deg45),
  .v_deg90(v_deg90), .w_deg90(w_deg90),
  .auto_mode(auto_mode), .ang_first(ang_first), .ang_second(ang_second),
  .proj_sel(proj_sel), .sig_x(sig_x), .sig_y(sig_y),
  .tick_cnt(tick_cnt), .alt_q(alt_q)
);

// File: tb/xy_scope_router_tb_top.sv
`timescale 1ns/1ps
module xy_scope_router_tb_top;
  localparam int DIV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [13:0] sv [0:2][0:2];
  logic auto_mode = 1'b0;
  logic [1:0] ang_first = 2'd0, ang_second = 2'd0, proj_sel = 2'd0;
  logic [13:0] sig_x, sig_y;
  logic dac_clk;

  int checks = 0, fails = 0;
  int ecount = 0;
  int stamp = 0;
  bit done = 0;
  logic [13:0] qx[$], qy[$];
  string qr[$];

  always #4 clk = ~clk;

  initial begin
    for (int a = 0; a < 3; a++)
      for (int c = 0; c < 3; c++) sv[a][c] = 14'(a * 4096 + c * 1024 + 7);
  end

  xy_scope_router #(.W(14), .TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .u_deg0(sv[0][0]),  .v_deg0(sv[0][1]),  .w_deg0(sv[0][2]),
    .u_deg45(sv[1][0]), .v_deg45(sv[1][1]), .w_deg45(sv[1][2]),
    .u_deg90(sv[2][0]), .v_deg90(sv[2][1]), .w_deg90(sv[2][2]),
    .auto_mode(auto_mode), .ang_first(ang_first), .ang_second(ang_second),
    .proj_sel(proj_sel), .sig_x(sig_x), .sig_y(sig_y), .dac_clk(dac_clk)
  );

  // bench-side count of rising edges since reset release
  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else ecount <= ecount + 1;
  end

  task automatic check(input string req, input logic [13:0] ax, ay, ex, ey);
    checks++;
    if (ax !== ex || ay !== ey) begin
      fails++;
      $display("FAIL %s: got x=%h y=%h expected x=%h y=%h", req, ax, ay, ex, ey);
    end
  endtask

  task automatic drive(input string req, input logic am, input logic [1:0] a1, a2, pr);
    int ang;
    bit ph;
    logic [13:0] ex, ey;
    @(negedge clk);
    stamp++;
    for (int a = 0; a < 3; a++)
      for (int c = 0; c < 3; c++) sv[a][c] = 14'(a * 4096 + c * 1024 + (stamp % 1024));
    auto_mode = am; ang_first = a1; ang_second = a2; proj_sel = pr;
    ph  = ((ecount / DIV) % 2) == 1;
    ang = (am && ph) ? int'(a2) : int'(a1);
    if (ang == 3) ang = 0;
    case (pr)
      2'd1:    begin ex = sv[ang][0]; ey = sv[ang][2]; end
      2'd2:    begin ex = sv[ang][1]; ey = sv[ang][2]; end
      default: begin ex = sv[ang][0]; ey = sv[ang][1]; end
    endcase
    qx.push_back(ex); qy.push_back(ey); qr.push_back(req);
  endtask

  // monitor: compare each registered result against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (qx.size() != 0) check(qr.pop_front(), sig_x, sig_y, qx.pop_front(), qy.pop_front());
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: outputs held at zero during reset
    auto_mode = 1'b1; ang_first = 2'd2; proj_sel = 2'd1;
    repeat (3) @(negedge clk);
    check("R1", sig_x, sig_y, 14'd0, 14'd0);
    // R8: forwarded DAC clock
    checks++; if (dac_clk !== clk) begin fails++; $display("FAIL R8: got %b expected %b", dac_clk, clk); end
    #4;
    checks++; if (dac_clk !== clk) begin fails++; $display("FAIL R8: got %b expected %b", dac_clk, clk); end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: first automatic output after release comes from the first angle
    drive("R1", 1'b1, 2'd1, 2'd2, 2'd0);
    // R2 / R4 / R5 / R7: sweep of all codes, switches change every cycle
    for (int a = 0; a < 4; a++)
      for (int p = 0; p < 4; p++)
        drive((a == 3) ? "R5" : (p == 3) ? "R4" : "R2_R7", 1'b0, 2'(a), 2'(3 - a), 2'(p));
    // R3: manual mode across several ticks, second angle wiggling
    for (int k = 0; k < 3 * DIV; k++) drive("R3", 1'b0, 2'd1, 2'(k % 4), 2'd1);
    // R6: automatic alternation over several ticks
    for (int k = 0; k < 4 * DIV; k++) drive("R6", 1'b1, 2'd0, 2'd2, 2'd2);
    for (int k = 0; k < 2 * DIV; k++) drive("R6", 1'b1, 2'd2, 2'd1, 2'd1);
    // R5: invalid angle codes in automatic mode
    for (int k = 0; k < 2 * DIV; k++) drive("R5", 1'b1, 2'd3, 2'd3, 2'd0);
    for (int k = 0; k < 2 * DIV; k++) drive("R5_R4", 1'b1, 2'd1, 2'd3, 2'd3);

    // R1: reset during the second phase restarts on the first angle
    while (((ecount / DIV) % 2) != 1 || (ecount % DIV) < 3) drive("R6", 1'b1, 2'd1, 2'd2, 2'd0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", sig_x, sig_y, 14'd0, 14'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive("R1", 1'b1, 2'd1, 2'd2, 2'd0);
    for (int k = 0; k < 2 * DIV; k++) drive("R6", 1'b1, 2'd1, 2'd2, 2'd0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule